// File: doc/BRIEF.md
# PCM Frame-Synced Serial Port

This block is the digital serial side of a telephony PCM codec. A transmit half sends one 8-bit code word per frame on a serial data line, and a receive half collects one 8-bit word per frame from another serial line. Each half has its own bit clock and its own 8 kHz frame sync pulse, and each pulse opens one time slot. Bit clocks, syncs and serial data are oversampled on the system clock `clk`, which must run several times faster than the fastest bit clock (64 kHz to 2.048 MHz). Edges are found by comparing each input with its value on the previous `clk` cycle.

The block recognises two sync formats from the sync's own width. A sync that is one bit period wide (short) places the first data bit one bit period after the slot opens. A sync three to eight bit periods wide (long) places the first bit at the slot opening. The transmit pad is driven only inside the slot, and an active-low slot strobe marks the same window. A shared-clock select runs both halves from the transmit bit clock. A power-down input freezes all slot activity.

Words from the core enter through a valid/ready port backed by a one-word holding register. `tx_ready` stays low while that register holds a word, so the core must wait. The holding register empties at the next slot start. Received words leave through a valid-only port, because a serial line cannot be stalled: `rx_valid` is a single-cycle strobe, and the core must take `rx_data` in that cycle or the word is lost.

Top module: `pcm_serial_port`

## Requirements
- R1: Outside a transmit slot, `ser_tx_en` is 0. A slot opens on the `clk` cycle after a bit-clock rising edge on which the frame sync is sampled 1, provided it was sampled 0 on the previous rising edge. From that cycle `ser_tx_en` is 1 and `ser_tx` carries the word's MSB.
- R2: The word is sent MSB first. Each bit changes only on a transmit bit-clock rising edge.
- R3: Long format: the sync is still 1 on the second rising edge of the slot. Bits 7..0 occupy the bit periods that start at rising edges 0..7 of the slot, and `ser_tx_en` falls at edge 8.
- R4: Short format: the sync is 0 on the second rising edge of the slot. The MSB is held through edges 0 and 1, bits 6..0 follow on edges 2..8, and `ser_tx_en` falls at edge 9.
- R5: The receive half samples `ser_rx` on falling edges of its bit clock and uses the same slot and format rules as the transmit half. One `clk` cycle after the falling edge that carries the last bit, `rx_valid` pulses for one cycle with the 8-bit word, MSB first.
- R6: `tx_ready` is 1 exactly when the holding register is empty. A word accepted with `tx_valid && tx_ready` is the one sent in the next slot, and the register then empties. A slot that opens with no word waiting sends the idle code 8'hD5.
- R7: A new sync (sampled 0 then 1) during a slot restarts both halves at edge 0. The partial receive word is dropped without an `rx_valid`.
- R8: While `shared_clk` is 1, the receive half runs from `tx_bclk`, and `rx_bclk` has no effect on the received words.
- R9: While `pdn` is 1, no slot opens, any open slot ends, `ser_tx_en` is 0, `rx_valid` stays 0, and a word in the holding register is kept for later.
- R10: `slot_n` is 0 on exactly the cycles on which `ser_tx_en` is 1, and 1 on all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn | input | 1 | Power-down; high freezes all slot activity |
| shared_clk | input | 1 | High: receive half uses the transmit bit clock |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fsync | input | 1 | Transmit frame sync pulse |
| ser_tx | output | 1 | Transmit serial data to the pad |
| ser_tx_en | output | 1 | Pad output enable; the pad floats when low |
| slot_n | output | 1 | Active-low transmit slot strobe |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fsync | input | 1 | Receive frame sync pulse |
| ser_rx | input | 1 | Receive serial data |
| tx_valid | input | 1 | Core offers a transmit word |
| tx_ready | output | 1 | Holding register empty |
| tx_data | input | 8 | Transmit word |
| rx_valid | output | 1 | Single-cycle strobe: received word present |
| rx_data | output | 8 | Received word |

## Verification
The bench loops the transmit pad back to the receive input and drives both syncs together. It covers short syncs and long syncs of three and eight periods. A design that decided the format from the wrong edge would shift every word by one bit. The restart case sends a second sync mid-slot: a design that ignored it would emit a corrupt word, and one that failed to drop the partial word would emit two. Further runs use shared-clock mode with a fast garbage signal on `rx_bclk`, a slot with no word waiting (idle code), and power-down with a word queued, which catches a design that leaks a slot or drops the held word.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  // Frame sync format, decided on the second bit-clock edge of a slot.
  typedef enum logic {
    FMT_SHORT = 1'b0,
    FMT_LONG  = 1'b1
  } sync_fmt_e;

  // Edge pulses of one oversampled bit clock.
  typedef struct packed {
    logic rise;
    logic fall;
  } clk_edges_t;
endpackage

// File: rtl/pcm_edge_det.sv
module pcm_edge_det
  import pcm_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  output clk_edges_t edges
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  always_comb begin
    edges.rise = lvl & ~prev_q;
    edges.fall = ~lvl & prev_q;
  end
endmodule

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer
  import pcm_port_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int POS_W = $clog2(WORD_W + 2),
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pdn,
  input  logic             rise,
  input  logic             fsync,
  output logic             start,
  output logic             active,
  output logic [IDX_W-1:0] bit_idx,
  output logic             last_bit
);
  logic             fs_last_q;
  logic             active_q;
  sync_fmt_e        fmt_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_nx;
  sync_fmt_e        fmt_nx;
  logic [POS_W-1:0] end_pos;
  logic [POS_W-1:0] sel;

  assign start = rise & fsync & ~fs_last_q & ~pdn;

  always_comb begin
    pos_nx  = pos_q + POS_W'(1);
    fmt_nx  = (pos_nx == POS_W'(1)) ? (fsync ? FMT_LONG : FMT_SHORT) : fmt_q;
    end_pos = (fmt_nx == FMT_LONG) ? POS_W'(WORD_W) : POS_W'(WORD_W + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_last_q <= 1'b0;
      active_q  <= 1'b0;
      fmt_q     <= FMT_LONG;
      pos_q     <= '0;
    end else begin
      if (rise) fs_last_q <= fsync;
      if (pdn) begin
        active_q <= 1'b0;
        fmt_q    <= FMT_LONG;
        pos_q    <= '0;
      end else if (start) begin
        active_q <= 1'b1;
        fmt_q    <= FMT_LONG;
        pos_q    <= '0;
      end else if (rise && active_q) begin
        pos_q <= pos_nx;
        fmt_q <= fmt_nx;
        if (pos_nx == end_pos) active_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (fmt_q == FMT_LONG || pos_q == '0) sel = pos_q;
    else                                  sel = pos_q - POS_W'(1);
  end

  assign bit_idx  = sel[IDX_W-1:0];
  assign active   = active_q;
  assign last_bit = active_q & (sel == POS_W'(WORD_W - 1));

  AST_PDN_CLOSES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    pdn |=> !active_q); // R9
  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> pos_q <= POS_W'(WORD_W)); // R4
  AST_FMT_HELD_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !rise && !pdn |=> $stable(fmt_q) && $stable(pos_q)); // R3
  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active_q && pos_q == '0); // R1
endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path #(
  parameter int              WORD_W    = 8,
  parameter logic [WORD_W-1:0] IDLE_CODE = 8'hD5,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdn,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  input  logic              start,
  input  logic              active,
  input  logic [IDX_W-1:0]  bit_idx,
  output logic              pin_d,
  output logic              pin_en
);
  logic [WORD_W-1:0] hold_q;
  logic              hold_full_q;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  pick;

  assign s_ready = ~hold_full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      word_q      <= IDLE_CODE;
    end else begin
      if (start) begin
        word_q <= hold_full_q ? hold_q : IDLE_CODE;
        if (hold_full_q) hold_full_q <= 1'b0;
      end
      if (s_valid && !hold_full_q) begin
        hold_q      <= s_data;
        hold_full_q <= 1'b1;
      end
    end
  end

  assign pick   = IDX_W'(WORD_W - 1) - bit_idx;
  assign pin_en = active & ~pdn;
  assign pin_d  = pin_en & word_q[pick];

  AST_HOLD_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    start && hold_full_q |=> s_ready && word_q == $past(hold_q)); // R6
  AST_WORD_FROZEN_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    active && !start |=> $stable(word_q)); // R2
  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full_q && !start |=> hold_full_q && $stable(hold_q)); // R9
endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdn,
  input  logic              fall,
  input  logic              active,
  input  logic              last_bit,
  input  logic              din,
  output logic              m_valid,
  output logic [WORD_W-1:0] m_data
);
  logic [WORD_W-2:0] shift_q;
  logic              take;

  assign take = fall & active & ~pdn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      m_valid <= 1'b0;
      if (take) begin
        shift_q <= {shift_q[WORD_W-3:0], din};
        if (last_bit) begin
          m_valid <= 1'b1;
          m_data  <= {shift_q, din};
        end
      end
    end
  end

  AST_RXV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |=> !m_valid); // R5
  AST_RXV_QUIET_IN_PDN: assert property (@(posedge clk) disable iff (!rst_n)
    pdn |=> !m_valid); // R9
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_port_pkg::*;
#(
  parameter int                WORD_W    = 8,
  parameter logic [WORD_W-1:0] IDLE_CODE = 8'hD5,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdn,
  input  logic              shared_clk,
  input  logic              tx_bclk,
  input  logic              tx_fsync,
  output logic              ser_tx,
  output logic              ser_tx_en,
  output logic              slot_n,
  input  logic              rx_bclk,
  input  logic              rx_fsync,
  input  logic              ser_rx,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data
);
  clk_edges_t       tx_e, rx_e;
  logic             rx_bclk_eff;
  logic             tx_start, tx_active, tx_last;
  logic [IDX_W-1:0] tx_idx;
  logic             rx_start, rx_active, rx_last;
  logic [IDX_W-1:0] rx_idx;

  assign rx_bclk_eff = shared_clk ? tx_bclk : rx_bclk;

  pcm_edge_det u_tx_edge (.clk(clk), .rst_n(rst_n), .lvl(tx_bclk),     .edges(tx_e));
  pcm_edge_det u_rx_edge (.clk(clk), .rst_n(rst_n), .lvl(rx_bclk_eff), .edges(rx_e));

  pcm_slot_timer #(.WORD_W(WORD_W)) u_tx_timer (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .rise(tx_e.rise), .fsync(tx_fsync),
    .start(tx_start), .active(tx_active), .bit_idx(tx_idx), .last_bit(tx_last)
  );

  pcm_slot_timer #(.WORD_W(WORD_W)) u_rx_timer (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .rise(rx_e.rise), .fsync(rx_fsync),
    .start(rx_start), .active(rx_active), .bit_idx(rx_idx), .last_bit(rx_last)
  );

  pcm_tx_path #(.WORD_W(WORD_W), .IDLE_CODE(IDLE_CODE)) u_tx_path (
    .clk(clk), .rst_n(rst_n), .pdn(pdn),
    .s_valid(tx_valid), .s_ready(tx_ready), .s_data(tx_data),
    .start(tx_start), .active(tx_active), .bit_idx(tx_idx),
    .pin_d(ser_tx), .pin_en(ser_tx_en)
  );

  pcm_rx_path #(.WORD_W(WORD_W)) u_rx_path (
    .clk(clk), .rst_n(rst_n), .pdn(pdn),
    .fall(rx_e.fall), .active(rx_active), .last_bit(rx_last), .din(ser_rx),
    .m_valid(rx_valid), .m_data(rx_data)
  );

  assign slot_n = ~ser_tx_en;

  AST_TX_BIT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ser_tx_en && $past(ser_tx_en) && !$past(tx_e.rise) |-> $stable(ser_tx)); // R2
  AST_NO_DRIVE_IN_PDN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pdn) && pdn |-> !ser_tx_en && slot_n); // R9
  AST_RX_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start |=> !rx_valid); // R7
endmodule

// File: tb/test_pcm_serial_port.sv
module test_pcm_serial_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pdn = 1'b0, shared_clk = 1'b0;
  logic       tx_bclk = 1'b0, tx_fsync = 1'b0, rx_bclk = 1'b0, rx_fsync = 1'b0;
  logic       ser_tx, ser_tx_en, slot_n, ser_rx;
  logic       tx_valid = 1'b0, tx_ready, rx_valid;
  logic [7:0] tx_data = 8'h00, rx_data;

  localparam logic [7:0] IDLE = 8'hD5;

  always #2 clk = ~clk;

  assign ser_rx = ser_tx_en ? ser_tx : 1'b1;  // pad loopback

  pcm_serial_port i_pcm_serial_port (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .shared_clk(shared_clk),
    .tx_bclk(tx_bclk), .tx_fsync(tx_fsync), .ser_tx(ser_tx), .ser_tx_en(ser_tx_en),
    .slot_n(slot_n), .rx_bclk(rx_bclk), .rx_fsync(rx_fsync), .ser_rx(ser_rx),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit        m_pb = 0, m_fsl = 0, m_act = 0, m_lng = 1;
  int        m_pos = 0;
  logic [7:0] m_cur = IDLE;
  logic [7:0] m_txq[$];
  bit        m_samp[$];
  bit        m_rxv = 0;
  logic [7:0] m_rxw = 8'h00;

  function automatic int m_bidx();
    if (m_lng || m_pos == 0) return m_pos;
    return m_pos - 1;
  endfunction

  always @(posedge clk) if (rst_n) begin
    bit rise, fall, rdy_old;
    rise = tx_bclk && !m_pb;
    fall = !tx_bclk && m_pb;
    m_pb = tx_bclk;
    rdy_old = (m_txq.size() == 0);
    m_rxv = 0;
    if (pdn) begin
      m_act = 0; m_pos = 0; m_lng = 1;
      if (rise) m_fsl = tx_fsync;
    end else if (rise) begin
      if (tx_fsync && !m_fsl) begin
        m_act = 1; m_pos = 0; m_lng = 1;
        m_cur = (m_txq.size() > 0) ? m_txq.pop_front() : IDLE;
      end else if (m_act) begin
        m_pos++;
        if (m_pos == 1) m_lng = tx_fsync;
        if (m_pos == (m_lng ? 8 : 9)) m_act = 0;
      end
      m_fsl = tx_fsync;
    end
    if (!pdn && fall && m_act) begin
      m_samp.push_back(ser_rx);
      if (m_samp.size() > 16) void'(m_samp.pop_front());
      if (m_bidx() == 7) begin
        m_rxv = 1;
        for (int k = 0; k < 8; k++) m_rxw[7-k] = m_samp[m_samp.size()-8+k];
      end
    end
    if (tx_valid && rdy_old) m_txq.push_back(tx_data);
  end

  // ---------------- stimulus generator ----------------
  int         tph = 15, gcnt = 0;
  bit         fs_plan = 0, garbage = 0;
  logic [7:0] rxlog[$];

  task automatic compare();
    chk("R1", "ser_tx_en", ser_tx_en, m_act);
    chk("R10", "slot_n", slot_n, !m_act);
    chk("R6", "tx_ready", tx_ready, m_txq.size() == 0);
    chk("R5", "rx_valid", rx_valid, m_rxv);
    if (m_act) chk(m_lng ? "R3" : "R4", "ser_tx bit", ser_tx, m_cur[7 - m_bidx()]);
    if (m_rxv) chk("R5", "rx_data", rx_data, m_rxw);
    if (rx_valid) rxlog.push_back(rx_data);
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst_n) compare();
    tph = (tph + 1) % 16;
    gcnt++;
    if (tph == 4) begin tx_fsync = fs_plan; rx_fsync = fs_plan; end
    tx_bclk = (tph < 8);
    rx_bclk = garbage ? gcnt[1] : tx_bclk;
  endtask

  task automatic periods(input int n, input bit f);
    fs_plan = f;
    repeat (n * 16) tick();
  endtask

  task automatic sync(input int len);
    periods(len, 1);
    periods(12 - len, 0);
  endtask

  task automatic offer(input logic [7:0] w);
    while (!tx_ready) tick();
    tx_valid = 1'b1; tx_data = w;
    tick();
    tx_valid = 1'b0;
  endtask

  task automatic expect_words(input string req, input logic [7:0] w);
    chk(req, "word count", rxlog.size(), 1);
    if (rxlog.size() > 0) chk(req, "word value", rxlog[0], w);
    rxlog.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // reset state: R1 R6 R10
    chk("R1", "reset ser_tx_en", ser_tx_en, 0);
    chk("R10", "reset slot_n", slot_n, 1);
    chk("R6", "reset tx_ready", tx_ready, 1);
    chk("R5", "reset rx_valid", rx_valid, 0);
    periods(2, 0);

    offer(8'hA5);                       // long sync, 3 periods: R3
    sync(3);
    expect_words("R3", 8'hA5);

    offer(8'h3C);                       // short sync: R4
    sync(1);
    expect_words("R4", 8'h3C);

    offer(8'hC3);                       // long sync, 8 periods: R3 R6
    chk("R6", "ready low while held", tx_ready, 0);
    sync(8);
    chk("R6", "ready after slot", tx_ready, 1);
    expect_words("R3", 8'hC3);

    sync(1);                            // no word waiting: R6 idle code
    expect_words("R6", IDLE);

    offer(8'h11);                       // restart mid-slot: R7
    periods(3, 1);
    periods(2, 0);
    offer(8'h22);
    periods(3, 1);
    periods(9, 0);
    expect_words("R7", 8'h22);

    shared_clk = 1'b1; tick();          // shared clock, garbage rx clock: R8
    garbage = 1'b1;
    offer(8'h96);
    sync(1);
    expect_words("R8", 8'h96);
    offer(8'h4B);
    sync(3);
    expect_words("R8", 8'h4B);
    garbage = 1'b0; tick();
    shared_clk = 1'b0; tick();

    pdn = 1'b1;                         // power-down: R9
    offer(8'h77);
    sync(3);
    chk("R9", "no word in power-down", rxlog.size(), 0);
    chk("R9", "held word kept", tx_ready, 0);
    rxlog.delete();
    pdn = 1'b0;
    periods(1, 0);
    sync(3);
    expect_words("R9", 8'h77);

    periods(1, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule